// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

The controller watches eight already-synchronised input pins and raises one interrupt request per pin. Software picks, for each channel, whether the channel reacts to edges or to levels. Software then enables rising or falling edges, or a high or low active level, through a small word-addressed register bus. Enable registers have write-one set and clear aliases, so that software can change one channel without a read-modify-write.

In edge mode, an enabled edge sets a pending bit. That bit drives the channel's request until software writes a one to it in the status register. In level mode, the request follows the pin while the channel is enabled. The channel's falling enable bit then selects the active polarity, and a write of one to the status register flips that polarity instead of clearing anything. Independent of all enables, the block records every rising and falling transition in two sticky detect registers, which software clears by writing ones.

Edges are found by comparing each pin with its value on the previous clock. That previous-value register is zero after reset.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and all eight interrupt requests are low. Bits 31:8 of every read are always zero.
- R2: The register word addresses are as follows: 0 mode, 1 rising/high enable, 2 rising enable set alias, 3 rising enable clear alias, 4 falling/low enable, 5 falling enable set alias, 6 falling enable clear alias, 7 rise detect, 8 fall detect, 9 status. Bit n of each register belongs to channel n. A write to address 0, 1 or 4 replaces the whole register.
- R3: A one written to a bit of a set alias sets that enable bit, and a one written to a bit of a clear alias clears it. Zeros written to an alias leave the enable unchanged, and aliases read as zero.
- R4: A low-to-high change of a pin between two clocks sets its rise detect bit, and a high-to-low change sets its fall detect bit, whatever the enables are. Writing one to a detect bit clears it. If a new edge arrives in the same cycle as that write, the bit stays set.
- R5: In edge mode (mode bit 0), a rising edge with the rising enable set, or a falling edge with the falling enable set, raises the channel's request on the clock after the edge. The request stays high until a one is written to the channel's status bit. A new enabled edge in the same cycle as that write keeps it high.
- R6: In level mode (mode bit 1), the request equals the rising enable bit ANDed with the pin when the falling enable bit is 1, or with the inverted pin when the falling enable bit is 0. It follows the pin in the same cycle, with no clock delay.
- R7: In level mode, writing one to a status bit toggles that channel's falling enable bit, which flips the active level.
- R8: The status register reads back the current eight interrupt requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Synchronised pin levels |
| irq_out | output | 8 | Per-channel interrupt requests |

## Verification
The assertions assume that pin_in is already synchronous to clk and changes only between edges. They also assume that bus_we carries at most one write per cycle and that the pins are low during reset, so that no edge is seen at release. The bench drives pins and bus signals only on the falling clock edge and holds pins low through reset. The hold-until-cleared property on the edge pending state also assumes that the mode register is not rewritten in the same cycle. The bench changes mode only while no edge pending state is set.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] irq_out
);
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_REN  = AW'(1);
  localparam logic [AW-1:0] A_RSET = AW'(2);
  localparam logic [AW-1:0] A_RCLR = AW'(3);
  localparam logic [AW-1:0] A_FEN  = AW'(4);
  localparam logic [AW-1:0] A_FSET = AW'(5);
  localparam logic [AW-1:0] A_FCLR = AW'(6);
  localparam logic [AW-1:0] A_RISE = AW'(7);
  localparam logic [AW-1:0] A_FALL = AW'(8);
  localparam logic [AW-1:0] A_STAT = AW'(9);
  localparam int PADW = DW - NCH;

  logic [NCH-1:0] prev_q, mode_q, ren_q, fen_q, rise_q, fall_q, pend_q;
  logic [NCH-1:0] mode_d, ren_d, fen_d, rise_d, fall_d, pend_d;
  logic [NCH-1:0] wm, rise_ev, fall_ev, lvl_hit, rd_val;

  assign wm      = bus_wdata[NCH-1:0];
  assign rise_ev = pin_in & ~prev_q;
  assign fall_ev = ~pin_in & prev_q;
  assign lvl_hit = ren_q & ~(pin_in ^ fen_q);
  assign irq_out = (mode_q & lvl_hit) | (~mode_q & pend_q);

  always_comb begin
    mode_d = mode_q;
    ren_d  = ren_q;
    fen_d  = fen_q;
    rise_d = rise_q;
    fall_d = fall_q;
    pend_d = pend_q;
    if (bus_we) begin
      unique case (bus_addr)
        A_MODE: mode_d = wm;
        A_REN:  ren_d  = wm;
        A_RSET: ren_d  = ren_q | wm;
        A_RCLR: ren_d  = ren_q & ~wm;
        A_FEN:  fen_d  = wm;
        A_FSET: fen_d  = fen_q | wm;
        A_FCLR: fen_d  = fen_q & ~wm;
        A_RISE: rise_d = rise_q & ~wm;
        A_FALL: fall_d = fall_q & ~wm;
        A_STAT: begin
          pend_d = pend_q & ~(wm & ~mode_q);
          fen_d  = fen_q ^ (wm & mode_q);
        end
        default: ;
      endcase
    end
    rise_d = rise_d | rise_ev;
    fall_d = fall_d | fall_ev;
    pend_d = (pend_d | (rise_ev & ren_q) | (fall_ev & fen_q)) & ~mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      mode_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= pin_in;
      mode_q <= mode_d;
      ren_q  <= ren_d;
      fen_q  <= fen_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_MODE:  rd_val = mode_q;
      A_REN:   rd_val = ren_q;
      A_FEN:   rd_val = fen_q;
      A_RISE:  rd_val = rise_q;
      A_FALL:  rd_val = fall_q;
      A_STAT:  rd_val = irq_out;
      default: rd_val = '0;
    endcase
  end

  assign bus_rdata = {{PADW{1'b0}}, rd_val};
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int NCH = 8,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] pin_in,
  input logic [NCH-1:0] irq_out,
  input logic [NCH-1:0] mode_q,
  input logic [NCH-1:0] ren_q,
  input logic [NCH-1:0] fen_q,
  input logic [NCH-1:0] rise_q,
  input logic [NCH-1:0] pend_q
);
  logic [NCH-1:0] pin_seen;
  logic [NCH-1:0] st_clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_seen <= '0;
    else        pin_seen <= pin_in;

  assign st_clr = (bus_we && bus_addr == AW'(9)) ? bus_wdata[NCH-1:0] : '0;

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NCH] == '0);

  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(2)) |=> (($past(bus_wdata[NCH-1:0]) & ~ren_q) == '0));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(6)) |=> (($past(bus_wdata[NCH-1:0]) & fen_q) == '0));

  p_rise_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pin_in & ~pin_seen) & ~rise_q) == '0));

  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(0)) |=> (($past(pend_q & ~st_clr) & ~pend_q) == '0));

  p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ren_q & ~(pin_in ^ fen_q)) == (irq_out & mode_q));

  p_level_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(9)) |=> (fen_q == ($past(fen_q) ^ ($past(bus_wdata[NCH-1:0]) & $past(mode_q)))));

  p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(9)) |-> (bus_rdata[NCH-1:0] == irq_out));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .irq_out(irq_out), .mode_q(mode_q), .ren_q(ren_q), .fen_q(fen_q),
  .rise_q(rise_q), .pend_q(pend_q)
);

// File: tb/tb_pin_irq_ctrl.sv
`timescale 1ns/1ps
module tb_pin_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  irq_out;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pin_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq_out(irq_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = {24'hFFFFFF, d};
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pins(logic [7:0] p);
    @(negedge clk);
    pin_in = p;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq", {24'h0, irq_out}, 32'h0);
  endtask

  task automatic t_alias;
    logic [31:0] v;
    wr(4'd2, 8'h05); rd(4'd1, v); chk("R3 set alias", v, 32'h05);
    wr(4'd2, 8'h02); rd(4'd1, v); chk("R3 set keeps zeros", v, 32'h07);
    wr(4'd3, 8'h01); rd(4'd1, v); chk("R3 clear alias", v, 32'h06);
    rd(4'd2, v); chk("R3 alias reads zero", v, 32'h0);
    wr(4'd5, 8'hF0); wr(4'd6, 8'h30); rd(4'd4, v); chk("R2 falling enable", v, 32'hC0);
    wr(4'd1, 8'h00); wr(4'd4, 8'h00); rd(4'd1, v); chk("R2 direct write", v, 32'h0);
  endtask

  task automatic t_detect;
    logic [31:0] v;
    pins(8'h01);
    rd(4'd7, v); chk("R4 rise latched", v, 32'h01);
    chk("R4 no irq when disabled", {24'h0, irq_out}, 32'h0);
    pins(8'h00);
    rd(4'd8, v); chk("R4 fall latched", v, 32'h01);
    wr(4'd7, 8'h01); rd(4'd7, v); chk("R4 rise W1C", v, 32'h0);
    wr(4'd8, 8'h01);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd7; bus_wdata = 32'h02; pin_in = 8'h02;
    @(negedge clk);
    bus_we = 1'b0;
    rd(4'd7, v); chk("R4 edge beats clear", v, 32'h02);
    pins(8'h00);
    wr(4'd7, 8'hFF); wr(4'd8, 8'hFF);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(4'd2, 8'h02);
    pins(8'h02);
    chk("R5 rising irq", {24'h0, irq_out}, 32'h02);
    rd(4'd9, v); chk("R8 status read", v, 32'h02);
    pins(8'h00);
    repeat (3) @(negedge clk);
    chk("R5 irq held", {24'h0, irq_out}, 32'h02);
    wr(4'd9, 8'h02);
    chk("R5 W1C clears irq", {24'h0, irq_out}, 32'h0);
    wr(4'd5, 8'h04);
    pins(8'h04);
    chk("R5 rise not enabled on ch2", {24'h0, irq_out}, 32'h0);
    pins(8'h00);
    chk("R5 falling irq", {24'h0, irq_out}, 32'h04);
    pins(8'h04);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd9; bus_wdata = 32'h04; pin_in = 8'h00;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R5 edge beats clear", {24'h0, irq_out}, 32'h04);
    wr(4'd9, 8'h04);
    chk("R5 cleared after", {24'h0, irq_out}, 32'h0);
    wr(4'd1, 8'h00); wr(4'd4, 8'h00);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(4'd0, 8'h08); wr(4'd2, 8'h08); wr(4'd5, 8'h08);
    @(negedge clk); pin_in = 8'h08; #1;
    chk("R6 active high immediate", {24'h0, irq_out}, 32'h08);
    @(negedge clk); pin_in = 8'h00; #1;
    chk("R6 drops with pin", {24'h0, irq_out}, 32'h0);
    @(negedge clk); pin_in = 8'h08;
    wr(4'd3, 8'h08);
    chk("R6 master enable off", {24'h0, irq_out}, 32'h0);
    wr(4'd2, 8'h08); wr(4'd6, 8'h08);
    @(negedge clk); pin_in = 8'h00; #1;
    chk("R6 active low", {24'h0, irq_out}, 32'h08);
    wr(4'd9, 8'h08);
    chk("R7 toggle leaves high level", {24'h0, irq_out}, 32'h0);
    rd(4'd4, v); chk("R7 polarity toggled", v, 32'h08);
    rd(4'd9, v); chk("R8 level status", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alias();
    t_detect();
    t_edge();
    t_level();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule